// File: doc/BRIEF.md
# Guarded Memory Access Window

This block sits between a host register bus and the two local memories of a compute coprocessor. It decodes each bus address into one of two windows. One window covers the instruction memory and the other covers the data memory. An access that falls in a window is forwarded as a single word to a simple synchronous memory port. Read data comes back one cycle later, and the bus response is aligned to that latency.

Access is allowed only while the coprocessor is idle. When it is busy or locked, a read returns zero and a write never reaches memory. Any window access made while busy and not locked also produces a one-cycle illegal-access fatal pulse. Writes must carry all four byte enables. A partial write is dropped and answered with a bus error. The backing data memory holds 1024 words, but the window exposes only its lower 768 words.

Top module: `memwin_gate`

## Requirements
- R1: A byte address from 0x4000 to 0x5FFC selects instruction memory word (address - 0x4000) / 4. A read returns that word on `rdata_o` in the response cycle.
- R2: A byte address from 0x8000 to 0x8BFC selects data memory word (address - 0x8000) / 4. Data memory words 768 to 1023 can never be addressed through the bus.
- R3: An address outside both windows, including 0x8C00 to 0x8FFC, issues no memory request. Its read returns zero, and it raises neither an error nor an illegal-access pulse.
- R4: While `busy_i` or `locked_i` is high, neither memory request is raised. Reads therefore return zero, and writes leave memory unchanged.
- R5: A window access (read or write) made while `busy_i` is high and `locked_i` is low raises `illegal_o` for exactly the response cycle.
- R6: While `locked_i` is high, a window access never raises `illegal_o`.
- R7: A window write whose `be_i` is not 4'b1111 is not forwarded. It raises `err_o` in the response cycle, whatever the busy or locked state.
- R8: Each request cycle gives `rsp_valid_o` high in exactly the following cycle. `rsp_valid_o` is low after a cycle without a request.
- R9: After synchronous reset, `rsp_valid_o`, `rdata_o`, `err_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables; only 4'b1111 is accepted for writes |
| busy_i | input | 1 | Coprocessor is running an operation |
| locked_i | input | 1 | Coprocessor is locked after a fatal error |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | 32 | Read data, zero if blocked or missed |
| err_o | output | 1 | Bus error for a partial write |
| illegal_o | output | 1 | Illegal-access fatal pulse |
| imem_req_o | output | 1 | Instruction memory request |
| imem_we_o | output | 1 | Instruction memory write enable |
| imem_addr_o | output | 11 | Instruction memory word index |
| imem_wdata_o | output | 32 | Instruction memory write data |
| imem_rdata_i | input | 32 | Instruction memory read data, one cycle latency |
| dmem_req_o | output | 1 | Data memory request |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_addr_o | output | 10 | Data memory word index |
| dmem_wdata_o | output | 32 | Data memory write data |
| dmem_rdata_i | input | 32 | Data memory read data, one cycle latency |

## Verification
Directed accesses hit the first and last word of each window and the addresses just outside them. These show whether the window edges and the hidden upper part of the data memory are decoded correctly. Random accesses then mix reads and writes over both windows and outside them, under idle, busy, locked and busy-plus-locked states, with occasional partial byte enables. Each memory word is preloaded with a value unique to its index, so a read that returns the wrong word shows up. Reading a word back after a blocked or partial write shows whether that write leaked into memory. The busy-only and locked cases tell the illegal-access pulse apart from plain blocking.

// File: rtl/memwin_pkg.sv
// Shared types for the guarded memory window.
// Assumes: only two windows exist, so a 2-bit selector suffices.
package memwin_pkg;
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_IMEM = 2'd1,
        WIN_DMEM = 2'd2
    } win_e;
endpackage

// File: rtl/memwin_decode.sv
// Address decoder: maps a byte address to a window and a word index.
// Assumes: windows do not overlap; the low two address bits must be zero
// for a hit only in the sense that the whole offset is range-compared.
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned IMEM_BASE   = 32'h4000,
    parameter int unsigned IMEM_WORDS  = 2048,
    parameter int unsigned DMEM_BASE   = 32'h8000,
    parameter int unsigned DMEM_VIS    = 768,
    parameter int unsigned IMEM_IW     = 11,
    parameter int unsigned DMEM_IW     = 10
) (
    input  logic [AW-1:0]      addr_i,
    output win_e               win_o,
    output logic [IMEM_IW-1:0] imem_idx_o,
    output logic [DMEM_IW-1:0] dmem_idx_o
);
    localparam logic [AW-1:0] IMEM_LO    = AW'(IMEM_BASE);
    localparam logic [AW-1:0] DMEM_LO    = AW'(DMEM_BASE);
    localparam int unsigned   IMEM_BYTES = IMEM_WORDS * 4;
    localparam int unsigned   DMEM_BYTES = DMEM_VIS * 4;

    logic [AW-1:0] imem_off, dmem_off;
    logic          imem_hit, dmem_hit;

    assign imem_off = addr_i - IMEM_LO;
    assign dmem_off = addr_i - DMEM_LO;

    // Range compare of each window.
    always_comb begin
        imem_hit = (addr_i >= IMEM_LO) && (32'(imem_off) < IMEM_BYTES);
        dmem_hit = (addr_i >= DMEM_LO) && (32'(dmem_off) < DMEM_BYTES);
    end

    // Pick the window and derive word indices.
    always_comb begin
        if (imem_hit)      win_o = WIN_IMEM;
        else if (dmem_hit) win_o = WIN_DMEM;
        else               win_o = WIN_NONE;
        imem_idx_o = imem_off[IMEM_IW+1:2];
        dmem_idx_o = dmem_off[DMEM_IW+1:2];
    end
endmodule

// File: rtl/memwin_rsp.sv
// Response stage: registers the response flags one cycle after a request
// and selects read data from the memory that was read.
// Assumes: memories return read data exactly one cycle after their request.
module memwin_rsp
    import memwin_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  win_e          rd_sel_i,
    input  logic          err_i,
    input  logic          illegal_i,
    input  logic [DW-1:0] imem_rdata_i,
    input  logic [DW-1:0] dmem_rdata_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rdata_o,
    output logic          err_o,
    output logic          illegal_o
);
    win_e sel_q;

    // Capture response flags for the next cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_o <= 1'b0;
            sel_q       <= WIN_NONE;
            err_o       <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            rsp_valid_o <= req_i;
            sel_q       <= req_i ? rd_sel_i : WIN_NONE;
            err_o       <= req_i && err_i;
            illegal_o   <= req_i && illegal_i;
        end
    end

    // Return data only from the memory actually read, else zero.
    always_comb begin
        case (sel_q)
            WIN_IMEM: rdata_o = imem_rdata_i;
            WIN_DMEM: rdata_o = dmem_rdata_i;
            default:  rdata_o = '0;
        endcase
    end

    assert_rsp_after_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o);
    assert_rsp_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_valid_o);
    assert_data_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> rdata_o == '0);
endmodule

// File: rtl/memwin_gate.sv
// Guarded memory window: forwards word accesses from the host bus to the
// instruction and data memories only while the coprocessor is idle.
// Assumes: one request per cycle at most, synchronous memories with one
// cycle read latency, and busy/locked stable during a request cycle.
module memwin_gate
    import memwin_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned DW         = 32,
    parameter int unsigned IMEM_WORDS = 2048,
    parameter int unsigned DMEM_WORDS = 1024,
    parameter int unsigned DMEM_VIS   = 768,
    parameter int unsigned IMEM_BASE  = 32'h4000,
    parameter int unsigned DMEM_BASE  = 32'h8000,
    localparam int unsigned IMEM_IW   = $clog2(IMEM_WORDS),
    localparam int unsigned DMEM_IW   = $clog2(DMEM_WORDS),
    localparam int unsigned BW        = DW / 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [BW-1:0]      be_i,
    input  logic               busy_i,
    input  logic               locked_i,
    output logic               rsp_valid_o,
    output logic [DW-1:0]      rdata_o,
    output logic               err_o,
    output logic               illegal_o,
    output logic               imem_req_o,
    output logic               imem_we_o,
    output logic [IMEM_IW-1:0] imem_addr_o,
    output logic [DW-1:0]      imem_wdata_o,
    input  logic [DW-1:0]      imem_rdata_i,
    output logic               dmem_req_o,
    output logic               dmem_we_o,
    output logic [DMEM_IW-1:0] dmem_addr_o,
    output logic [DW-1:0]      dmem_wdata_o,
    input  logic [DW-1:0]      dmem_rdata_i
);
    win_e win;
    logic in_win, idle, full_word, fwd, err_d, illegal_d;
    win_e rd_sel;

    memwin_decode #(
        .AW(AW), .IMEM_BASE(IMEM_BASE), .IMEM_WORDS(IMEM_WORDS),
        .DMEM_BASE(DMEM_BASE), .DMEM_VIS(DMEM_VIS),
        .IMEM_IW(IMEM_IW), .DMEM_IW(DMEM_IW)
    ) u_decode (
        .addr_i     (addr_i),
        .win_o      (win),
        .imem_idx_o (imem_addr_o),
        .dmem_idx_o (dmem_addr_o)
    );

    // Gate: decide whether the access may reach memory and which flags it raises.
    always_comb begin
        in_win    = (win != WIN_NONE);
        idle      = !busy_i && !locked_i;
        full_word = &be_i;
        fwd       = req_i && in_win && idle && (!we_i || full_word);
        err_d     = in_win && we_i && !full_word;
        illegal_d = in_win && busy_i && !locked_i;
        rd_sel    = (fwd && !we_i) ? win : WIN_NONE;
    end

    // Drive the memory ports.
    always_comb begin
        imem_req_o   = fwd && (win == WIN_IMEM);
        dmem_req_o   = fwd && (win == WIN_DMEM);
        imem_we_o    = we_i;
        dmem_we_o    = we_i;
        imem_wdata_o = wdata_i;
        dmem_wdata_o = wdata_i;
    end

    memwin_rsp #(.DW(DW)) u_rsp (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req_i),
        .rd_sel_i     (rd_sel),
        .err_i        (err_d),
        .illegal_i    (illegal_d),
        .imem_rdata_i (imem_rdata_i),
        .dmem_rdata_i (dmem_rdata_i),
        .rsp_valid_o  (rsp_valid_o),
        .rdata_o      (rdata_o),
        .err_o        (err_o),
        .illegal_o    (illegal_o)
    );

    assert_blocked_no_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i || locked_i) |-> !(imem_req_o || dmem_req_o));
    assert_blocked_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && (busy_i || locked_i)) |=> rdata_o == '0);
    assert_illegal_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> $past(req_i && busy_i));
    assert_locked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && locked_i) |=> !illegal_o);
    assert_partial_dropped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && !(&be_i)) |-> !(imem_req_o || dmem_req_o));
    assert_one_memory_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(imem_req_o && dmem_req_o));
endmodule

// File: tb/memwin_gate_tb_top.sv
`timescale 1ns/1ps
module memwin_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, busy = 1'b0, locked = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = 4'hF;
    logic        rsp_valid, err, illegal;
    logic [31:0] rdata;
    logic        imem_req, imem_we, dmem_req, dmem_we;
    logic [10:0] imem_addr;
    logic [9:0]  dmem_addr;
    logic [31:0] imem_wdata, dmem_wdata;
    logic [31:0] imem_rdata = '0, dmem_rdata = '0;

    logic [31:0] imem_mem [2048];
    logic [31:0] dmem_mem [1024];
    logic [31:0] sh_imem  [2048];
    logic [31:0] sh_dmem  [1024];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    memwin_gate dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .busy_i(busy), .locked_i(locked),
        .rsp_valid_o(rsp_valid), .rdata_o(rdata), .err_o(err), .illegal_o(illegal),
        .imem_req_o(imem_req), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
        .imem_wdata_o(imem_wdata), .imem_rdata_i(imem_rdata),
        .dmem_req_o(dmem_req), .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
        .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata)
    );

    // Bench memories with one cycle read latency.
    always @(posedge clk) begin
        if (imem_req) begin
            if (imem_we) imem_mem[imem_addr] <= imem_wdata;
            imem_rdata <= imem_mem[imem_addr];
        end
        if (dmem_req) begin
            if (dmem_we) dmem_mem[dmem_addr] <= dmem_wdata;
            dmem_rdata <= dmem_mem[dmem_addr];
        end
    end

    function automatic logic [31:0] pat(input int k, input int i);
        return (k == 0 ? 32'hA100_0000 : 32'hD200_0000) ^ (32'(i) * 32'h0001_0003);
    endfunction

    // Window of an address: 0 none, 1 instruction, 2 data.
    function automatic int win_of(input logic [15:0] a);
        if (a >= 16'h4000 && a <= 16'h5FFF) return 1;
        if (a >= 16'h8000 && a <= 16'h8BFF) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit w, input logic [3:0] b,
                          input logic [31:0] d, input bit bsy, input bit lck);
        int wn;
        int idx;
        bit allowed;
        logic [31:0] exp_rd;
        bit exp_err, exp_ill;
        string tag;
        wn = win_of(a);
        idx = (wn == 1) ? int'((a - 16'h4000) >> 2) : int'((a - 16'h8000) >> 2);
        allowed = (wn != 0) && !bsy && !lck && (!w || b == 4'hF);
        exp_rd = '0;
        if (allowed && !w) exp_rd = (wn == 1) ? sh_imem[idx] : sh_dmem[idx];
        exp_err = (wn != 0) && w && (b != 4'hF);
        exp_ill = (wn != 0) && bsy && !lck;
        if (wn == 0)              tag = "R3";
        else if (lck)             tag = "R4/R6";
        else if (bsy)             tag = "R4/R5";
        else if (wn == 1)         tag = "R1";
        else                      tag = "R2";
        @(negedge clk);
        req = 1'b1; we = w; addr = a; be = b; wdata = d; busy = bsy; locked = lck;
        @(negedge clk);
        req = 1'b0;
        chk(rsp_valid === 1'b1, "R8 rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rdata === exp_rd, {tag, " rdata"}, rdata, exp_rd);
        chk(err === exp_err, exp_err ? "R7 err" : {tag, " err"}, 32'(err), 32'(exp_err));
        chk(illegal === exp_ill, lck ? "R6 illegal" : (wn == 0 ? "R3 illegal" : "R5 illegal"),
            32'(illegal), 32'(exp_ill));
        if (allowed && w) begin
            if (wn == 1) sh_imem[idx] = d; else sh_dmem[idx] = d;
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin imem_mem[i] = pat(0, i); sh_imem[i] = pat(0, i); end
        for (int i = 0; i < 1024; i++) begin dmem_mem[i] = pat(1, i); sh_dmem[i] = pat(1, i); end
        void'($urandom(32'd20240611));
        req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        // R9: reset state
        chk(rsp_valid === 1'b0 && rdata === '0 && err === 1'b0 && illegal === 1'b0,
            "R9 reset outputs", {rsp_valid, err, illegal, 29'd0} | rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8 idle no rsp", 32'(rsp_valid), 32'd0);
        // Window edges
        access(16'h4000, 0, 4'hF, 0, 0, 0);                     // R1 first word
        access(16'h5FFC, 0, 4'hF, 0, 0, 0);                     // R1 last word
        access(16'h8000, 0, 4'hF, 0, 0, 0);                     // R2 first word
        access(16'h8BFC, 0, 4'hF, 0, 0, 0);                     // R2 last visible word
        access(16'h8C00, 0, 4'hF, 0, 0, 0);                     // R3 hidden part
        access(16'h8FFC, 1, 4'hF, 32'hBAD0_0001, 0, 0);         // R3 hidden write
        access(16'h3FFC, 0, 4'hF, 0, 0, 0);                     // R3 below
        access(16'h6000, 0, 4'hF, 0, 0, 0);                     // R3 above
        chk(dmem_mem[1023] === pat(1, 1023), "R2 hidden word untouched", dmem_mem[1023], pat(1, 1023));
        // Blocked writes then readback
        access(16'h4010, 1, 4'hF, 32'h1111_2222, 1, 0);         // R5 busy write
        access(16'h8010, 1, 4'hF, 32'h3333_4444, 0, 1);         // R6 locked write
        access(16'h8014, 1, 4'hF, 32'h5555_6666, 1, 1);         // R6 busy and locked
        access(16'h4014, 1, 4'h7, 32'h7777_8888, 0, 0);         // R7 partial write
        access(16'h4010, 0, 4'hF, 0, 0, 0);                     // R4 readback
        access(16'h8010, 0, 4'hF, 0, 0, 0);                     // R4 readback
        access(16'h8014, 0, 4'hF, 0, 0, 0);                     // R4 readback
        access(16'h4014, 0, 4'hF, 0, 0, 0);                     // R7 readback
        access(16'h4020, 1, 4'hF, 32'hCAFE_F00D, 0, 0);         // R1 write
        access(16'h4020, 0, 4'hF, 0, 1, 0);                     // R4 busy read zero
        access(16'h4020, 0, 4'hF, 0, 0, 0);                     // R1 readback
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            int r;
            bit w, bsy, lck;
            logic [3:0] b;
            r = $urandom_range(0, 9);
            if (r < 4)      a = 16'h4000 + 16'($urandom_range(0, 2047) * 4);
            else if (r < 8) a = 16'h8000 + 16'($urandom_range(0, 1023) * 4);
            else            a = 16'($urandom());
            w = $urandom_range(0, 1);
            bsy = ($urandom_range(0, 4) == 0);
            lck = ($urandom_range(0, 6) == 0);
            b = ($urandom_range(0, 5) == 0) ? 4'($urandom()) : 4'hF;
            access(a, w, b, $urandom(), bsy, lck);
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule